// File: doc/BRIEF.md
# Shared Exclusive-Access Reservation Monitor

This block sits beside the memory ports of a small multiprocessor and decides the outcome of load-exclusive / store-exclusive pairs. When a CPU issues a load-exclusive, the monitor records which 8-byte granule that CPU has reserved. A later store-exclusive from the same CPU succeeds only if the reservation is still intact. The monitor also watches every completed write from the other CPUs, so that a write into a reserved granule breaks the reservation. The monitor lives outside the cores and sees only port traffic. Events inside a core, such as traps, translation misses or mispredicted branches, therefore cannot disturb a reservation.

Each port presents one request per cycle: a valid bit, a two-bit kind and an address. One cycle later the block returns a response with two flags. One tells whether the access wrote memory. The other is the exclusive status, where 0 means success and 1 means failure. A failed store-exclusive starts a per-CPU backoff counter. The counter length scales with the CPU number, so that competing retries are staggered and cannot livelock. While the counter runs, that CPU's ready output is held low.

Top module: `excl_monitor`

## Requirements
- R1: After reset, all reservations are open, all response outputs are 0 and every ready output is 1.
- R2: A request uses kind encoding 00 = load, 01 = store, 10 = load-exclusive and 11 = store-exclusive. Lane i uses kind bits [2i+1:2i] and address bits [i*AW+AW-1:i*AW]. A store-exclusive that matches its own CPU's reservation succeeds: the status is 0 and the write flag is 1.
- R3: A store-exclusive from a CPU with no reservation, or with a reservation on a different granule, fails. The status is 1 and the write flag is 0.
- R4: Addresses match on the granule, which is the address with its low GRAN_LG2 bits dropped. A CPU's own ordinary loads and stores, and other CPUs' loads, leave its reservation in place.
- R5: A completed write from another CPU into a reserved granule clears that reservation. The write may be an ordinary store or a winning store-exclusive. A write to a different granule has no effect.
- R6: Any store-exclusive, whether it succeeds or fails, returns the issuing CPU's monitor to open.
- R7: A new load-exclusive replaces that CPU's earlier reservation.
- R8: When several CPUs issue store-exclusive in one cycle to a granule each has reserved, only the lowest-numbered one succeeds. The others fail.
- R9: A store-exclusive fails if another CPU completes an ordinary store to the same granule in the same cycle. The ordinary store is performed.
- R10: After a failure response for CPU i, ready[i] is low for exactly (i+1)*BACKOFF_BASE consecutive cycles, starting in the cycle of that response.
- R11: Each response appears exactly one cycle after its request. The status bit is 1 only on the response to a failed store-exclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCPU | Request present, one bit per CPU |
| req_kind | input | 2*NCPU | Access kind per CPU |
| req_addr | input | NCPU*AW | Physical address per CPU |
| rsp_valid | output | NCPU | Response present, one cycle after the request |
| rsp_fail | output | NCPU | Exclusive status: 1 means the store-exclusive failed |
| rsp_wrote | output | NCPU | The access wrote memory |
| retry_ready | output | NCPU | Low while the CPU's backoff counter is running |

## Verification
The hardest case is the same-cycle collision. Several CPUs must hold a reservation on one granule and then fire store-exclusive together. A variant adds an ordinary store from a third CPU into that granule in the same cycle. The stimulus first issues simultaneous load-exclusives from every lane. It then sweeps all fifteen non-empty subsets of four CPUs as concurrent store-exclusives, and checks that the winner is the lowest set bit in each subset. A sweep over every ordered CPU pair covers cross-CPU clearing for both kinds of write, and also checks that a write to a neighbouring granule leaves the reservation alone.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
    typedef enum logic [1:0] {
        K_LD = 2'b00,
        K_ST = 2'b01,
        K_LX = 2'b10,
        K_SX = 2'b11
    } acc_kind_e;
endpackage

// File: rtl/excl_arbiter.sv
module excl_arbiter
    import excl_mon_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int GW   = 29
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCPU-1:0]      valid,
    input  acc_kind_e            kind   [NCPU],
    input  logic [GW-1:0]        gran   [NCPU],
    input  logic [NCPU-1:0]      resv_v,
    input  logic [GW-1:0]        resv_g [NCPU],
    output logic [NCPU-1:0]      sx_fail,
    output logic [NCPU-1:0]      wr_done
);
    logic [NCPU-1:0] cand_d, plain_d, win_d;

    always_comb begin
        for (int i = 0; i < NCPU; i++) begin
            cand_d[i]  = valid[i] && kind[i] == K_SX && resv_v[i] && resv_g[i] == gran[i];
            plain_d[i] = valid[i] && kind[i] == K_ST;
        end
        for (int i = 0; i < NCPU; i++) begin
            win_d[i] = cand_d[i];
            for (int j = 0; j < NCPU; j++) begin
                // an ordinary store from another CPU in the same cycle beats it
                if (j != i && plain_d[j] && gran[j] == gran[i]) win_d[i] = 1'b0;
                // lower CPU number wins among contenders for one granule
                if (j < i && cand_d[j] && gran[j] == gran[i]) win_d[i] = 1'b0;
            end
        end
        for (int i = 0; i < NCPU; i++) begin
            sx_fail[i] = valid[i] && kind[i] == K_SX && !win_d[i];
            wr_done[i] = plain_d[i] || win_d[i];
        end
    end

    for (genvar i = 0; i < NCPU; i++) begin : g_pair_i
        for (genvar j = i + 1; j < NCPU; j++) begin : g_pair_j
            p_single_winner_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !(win_d[i] && win_d[j] && gran[i] == gran[j]));
        end
    end
endmodule

// File: rtl/excl_backoff.sv
module excl_backoff #(
    parameter int NCPU = 4,
    parameter int BASE = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCPU-1:0] fail,
    output logic [NCPU-1:0] ready
);
    localparam int CW = $clog2(NCPU * BASE + 1);

    logic [CW-1:0] cnt_d [NCPU];
    logic [CW-1:0] cnt_q [NCPU];

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        localparam logic [CW-1:0] LOADV = CW'((i + 1) * BASE);

        always_comb begin
            cnt_d[i] = cnt_q[i];
            if (fail[i])               cnt_d[i] = LOADV;
            else if (cnt_q[i] != '0)   cnt_d[i] = cnt_q[i] - 1'b1;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q[i] <= '0;
            else        cnt_q[i] <= cnt_d[i];
        end

        assign ready[i] = (cnt_q[i] == '0);

        p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[i] <= LOADV);
        p_fail_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
            fail[i] |=> !ready[i]);
    end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_mon_pkg::*;
#(
    parameter int NCPU         = 4,
    parameter int AW           = 32,
    parameter int GRAN_LG2     = 3,
    parameter int BACKOFF_BASE = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCPU-1:0]      req_valid,
    input  logic [2*NCPU-1:0]    req_kind,
    input  logic [NCPU*AW-1:0]   req_addr,
    output logic [NCPU-1:0]      rsp_valid,
    output logic [NCPU-1:0]      rsp_fail,
    output logic [NCPU-1:0]      rsp_wrote,
    output logic [NCPU-1:0]      retry_ready
);
    localparam int GW = AW - GRAN_LG2;

    typedef struct packed {
        logic [NCPU-1:0]         rv;
        logic [NCPU-1:0][GW-1:0] rg;
        logic [NCPU-1:0]         rsp_v;
        logic [NCPU-1:0]         rsp_f;
        logic [NCPU-1:0]         rsp_w;
    } mon_st_t;

    mon_st_t d, q;

    acc_kind_e       kind   [NCPU];
    logic [GW-1:0]   gran   [NCPU];
    logic [GW-1:0]   resv_g [NCPU];
    logic [NCPU-1:0] sx_fail, wr_done;
    logic [NCPU-1:0] hit_new, hit_old;

    for (genvar i = 0; i < NCPU; i++) begin : g_lane
        assign kind[i]   = acc_kind_e'(req_kind[2*i +: 2]);
        assign gran[i]   = req_addr[i*AW + GRAN_LG2 +: GW];
        assign resv_g[i] = q.rg[i];
    end

    excl_arbiter #(.NCPU(NCPU), .GW(GW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (req_valid),
        .kind    (kind),
        .gran    (gran),
        .resv_v  (q.rv),
        .resv_g  (resv_g),
        .sx_fail (sx_fail),
        .wr_done (wr_done)
    );

    excl_backoff #(.NCPU(NCPU), .BASE(BACKOFF_BASE)) u_boff (
        .clk   (clk),
        .rst_n (rst_n),
        .fail  (sx_fail),
        .ready (retry_ready)
    );

    always_comb begin
        d       = q;
        d.rsp_v = req_valid;
        d.rsp_f = sx_fail;
        d.rsp_w = wr_done;
        for (int k = 0; k < NCPU; k++) begin
            hit_new[k] = 1'b0;
            hit_old[k] = 1'b0;
            for (int j = 0; j < NCPU; j++) begin
                if (j != k && wr_done[j] && gran[j] == gran[k]) hit_new[k] = 1'b1;
                if (j != k && wr_done[j] && gran[j] == q.rg[k]) hit_old[k] = 1'b1;
            end
            if (req_valid[k] && kind[k] == K_LX) begin
                d.rv[k] = !hit_new[k];
                d.rg[k] = gran[k];
            end else if (req_valid[k] && kind[k] == K_SX) begin
                d.rv[k] = 1'b0;
            end else if (hit_old[k]) begin
                d.rv[k] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid = q.rsp_v;
    assign rsp_fail  = q.rsp_f;
    assign rsp_wrote = q.rsp_w;

    for (genvar i = 0; i < NCPU; i++) begin : g_chk
        p_sx_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && kind[i] == K_SX) |=> !q.rv[i]);
        p_fail_only_sx_r11: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_fail[i] |-> (rsp_valid[i] && !rsp_wrote[i]));
        p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[i] |=> rsp_valid[i]);
    end
endmodule

// File: tb/tb_excl_monitor.sv
module tb_excl_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int AW = 16;
    localparam int BB = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    req_valid;
    logic [2*N-1:0]  req_kind;
    logic [N*AW-1:0] req_addr;
    logic [N-1:0]    rsp_valid, rsp_fail, rsp_wrote, retry_ready;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    excl_monitor #(.NCPU(N), .AW(AW), .GRAN_LG2(3), .BACKOFF_BASE(BB)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_fail(rsp_fail),
        .rsp_wrote(rsp_wrote), .retry_ready(retry_ready));

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic lane(input int c, input logic [1:0] k, input logic [15:0] a);
        req_valid[c]        = 1'b1;
        req_kind[2*c +: 2]  = k;
        req_addr[AW*c +: AW] = a;
    endtask

    // advance one clock; responses to the driven requests are visible afterwards
    task automatic fire();
        @(posedge clk); #1;
        req_valid = '0;
    endtask

    task automatic drain();
        for (int t = 0; t < 4*N*BB + 2; t++) fire();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = '0; req_kind = '0; req_addr = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 rsp_fail", rsp_fail, 0);
        chk("R1 ready", retry_ready, 4'hF);
        // R1: no reservation exists after reset
        lane(2, 2'b11, 16'h0000); fire();
        chk("R1 sx after reset fails", rsp_fail[2], 1);
        drain();

        // R2 and R11
        lane(0, 2'b10, 16'h0040); fire();
        chk("R11 load-ex rsp", {rsp_valid[0], rsp_fail[0], rsp_wrote[0]}, 3'b100);
        lane(0, 2'b11, 16'h0040); fire();
        chk("R2 sx ok", {rsp_valid[0], rsp_fail[0], rsp_wrote[0]}, 3'b101);
        fire();
        chk("R11 no rsp w/o req", rsp_valid, 0);

        // R3: different granule
        lane(1, 2'b10, 16'h0040); fire();
        lane(1, 2'b11, 16'h0048); fire();
        chk("R3 wrong granule", {rsp_fail[1], rsp_wrote[1]}, 2'b10);
        // R6: reservation gone after the store-exclusive
        lane(1, 2'b11, 16'h0040); fire();
        chk("R6 second sx fails", rsp_fail[1], 1);
        lane(2, 2'b10, 16'h0050); fire();
        lane(2, 2'b11, 16'h0050); fire();
        lane(2, 2'b11, 16'h0050); fire();
        chk("R6 sx after success", rsp_fail[2], 1);
        drain();

        // R4: own traffic and others' loads keep the reservation; byte offset within granule
        lane(0, 2'b10, 16'h0080); fire();
        lane(0, 2'b01, 16'h0083); lane(1, 2'b00, 16'h0080); fire();
        chk("R4 own store writes", rsp_wrote[0], 1);
        lane(0, 2'b00, 16'h0080); lane(3, 2'b00, 16'h0084); fire();
        lane(0, 2'b11, 16'h0087); fire();
        chk("R4 sx survives", {rsp_fail[0], rsp_wrote[0]}, 2'b01);

        // R7
        lane(3, 2'b10, 16'h0100); fire();
        lane(3, 2'b10, 16'h0200); fire();
        lane(3, 2'b11, 16'h0100); fire();
        chk("R7 old granule fails", rsp_fail[3], 1);
        lane(3, 2'b10, 16'h0100); fire();
        lane(3, 2'b10, 16'h0200); fire();
        lane(3, 2'b11, 16'h0200); fire();
        chk("R7 new granule ok", rsp_fail[3], 0);
        drain();

        // R9
        lane(1, 2'b10, 16'h0300); fire();
        lane(1, 2'b11, 16'h0300); lane(3, 2'b01, 16'h0304); fire();
        chk("R9 sx loses", rsp_fail[1], 1);
        chk("R9 store done", rsp_wrote[3], 1);
        drain();

        // R5: every ordered pair
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                if (a != b) begin
                    lane(a, 2'b10, 16'h0400); fire();
                    lane(b, 2'b01, 16'h0404); fire();
                    lane(a, 2'b11, 16'h0400); fire();
                    chk($sformatf("R5 store clears a=%0d b=%0d", a, b), rsp_fail[a], 1);
                    lane(a, 2'b10, 16'h0400); fire();
                    lane(b, 2'b01, 16'h0408); fire();
                    lane(a, 2'b11, 16'h0400); fire();
                    chk($sformatf("R5 other granule a=%0d b=%0d", a, b), rsp_fail[a], 0);
                    lane(a, 2'b10, 16'h0400); lane(b, 2'b10, 16'h0400); fire();
                    lane(b, 2'b11, 16'h0400); fire();
                    chk($sformatf("R5 b sx wins a=%0d b=%0d", a, b), rsp_wrote[b], 1);
                    lane(a, 2'b11, 16'h0400); fire();
                    chk($sformatf("R5 sx-write clears a=%0d b=%0d", a, b), rsp_fail[a], 1);
                end
            end
        end
        drain();

        // R8: all non-empty subsets contend
        for (int m = 1; m < (1 << N); m++) begin
            int lo;
            lo = -1;
            for (int i = N - 1; i >= 0; i--) if (m[i]) lo = i;
            for (int i = 0; i < N; i++) lane(i, 2'b10, 16'h0500 + 16'(i));
            fire();
            for (int i = 0; i < N; i++) if (m[i]) lane(i, 2'b11, 16'h0500);
            fire();
            for (int i = 0; i < N; i++) begin
                if (m[i]) chk($sformatf("R8 mask=%0h cpu=%0d", m, i),
                              {rsp_fail[i], rsp_wrote[i]}, (i == lo) ? 2'b01 : 2'b10);
            end
        end
        drain();

        // R10: backoff length per CPU
        for (int i = 0; i < N; i++) begin
            int n;
            lane(i, 2'b11, 16'h0600); fire();
            n = 0;
            while (!retry_ready[i] && n < 100) begin
                n++;
                fire();
            end
            chk($sformatf("R10 backoff cpu=%0d", i), n, (i + 1) * BB);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule